// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a processor core: a linear stack of program-counter values that grows on every subroutine call or interrupt and shrinks on every return. The stack pointer and two sticky error flags are visible. The top entry can be read at any time and patched one byte lane at a time. The surrounding core supplies one command per cycle: push with a value, return (the top value is the return target), discard-pop, or a byte write to the top entry. It also drives a software flag-clear strobe and a synchronous device reset. The block drives a one-cycle reset request back to the core when an error occurs and error resets are enabled.

Level 0 is not storage. It reads as the all-zero reset vector. A return taken with the stack empty therefore hands the core address zero, which restarts the program without resetting the device. It also raises the underflow flag. Pushing beyond the last level does not move the pointer. The new value replaces the topmost entry and the full flag is raised. A one-level context shadow holds three 8-bit core registers. It is captured on an interrupt or fast call and is read back by the core on a fast return.

Top module: `retstack`

## Requirements
- R1: After power-on reset (`rst_ni` low) the pointer is 0, `tos_o` is 0, both flags are 0, `rst_req_o` is 0 and the shadow registers are 0.
- R2: A push below the top level increments the pointer, and the pushed value is stored in the new top entry, which then appears on `tos_o`.
- R3: `tos_o` holds the return address during a return, and the return decrements the pointer. A discard-pop only decrements the pointer. Neither changes entries below.
- R4: A push from level DEPTH-1 moves the pointer to DEPTH and sets `full_o`. A push at level DEPTH keeps the pointer at DEPTH, replaces the top entry and keeps `full_o` set.
- R5: A return or discard-pop at level 0 shows 0 on `tos_o`, keeps the pointer at 0 and sets `unf_o`.
- R6: `full_o` and `unf_o` stay set until `rst_ni` or `flag_clr_i` clears them. `dev_rst_i` returns the pointer to 0 but leaves both flags unchanged. A flag set and a clear in the same cycle leave the flag set.
- R7: With `err_rst_en_i` high, a command that sets a flag raises `rst_req_o` in the next cycle for exactly one cycle. With it low, `rst_req_o` stays 0.
- R8: A top-entry write with `tos_sel_i` = 0 replaces bits 7:0, with 1 replaces bits 15:8, and with 2 replaces bits 20:16 from data bits 4:0. Code 3 has no effect, and a write at level 0 has no effect.
- R9: A push with `push_fast_i` high copies `wreg_i`, `status_i` and `bsr_i` into the shadow. A push without it leaves the shadow unchanged.
- R10: Commands take effect in this priority: push, then return or discard-pop, then top-entry write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst_i | input | 1 | Synchronous device reset; clears pointer, keeps flags |
| push_i | input | 1 | Push command (call or interrupt) |
| push_fast_i | input | 1 | With push: save context into the shadow |
| push_pc_i | input | 21 | Value to push |
| wreg_i | input | 8 | Working register value to shadow |
| status_i | input | 8 | Status register value to shadow |
| bsr_i | input | 8 | Bank-select register value to shadow |
| ret_i | input | 1 | Return: consume top entry |
| drop_i | input | 1 | Discard-pop |
| tos_we_i | input | 1 | Write one byte lane of the top entry |
| tos_sel_i | input | 2 | Byte lane select (0 low, 1 middle, 2 upper) |
| tos_wdata_i | input | 8 | Byte to write |
| flag_clr_i | input | 1 | Software clear of both error flags |
| err_rst_en_i | input | 1 | Enable reset request on stack error |
| tos_o | output | 21 | Top entry, 0 at level 0; return address |
| sp_o | output | 5 | Stack pointer |
| full_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle device reset request |
| shd_wreg_o | output | 8 | Shadowed working register |
| shd_status_o | output | 8 | Shadowed status register |
| shd_bsr_o | output | 8 | Shadowed bank-select register |

## Verification
The properties treat command inputs as known 0/1 values. Their antecedents exclude a concurrent push or device reset, so the pointer-step checks do not cover the cases that the priority order settles. The bench issues one command at a time, with an idle cycle after each. It samples `tos_o` before a return to capture the address handed back. It steers the pointer to both ends of the stack before it tests the overflow and underflow paths, flag stickiness across a device reset, and the reset request with error resets enabled and disabled.

// File: rtl/retstack.sv
`timescale 1ns/1ps
module retstack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int CW    = 8,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_rst_i,
  input  logic          push_i,
  input  logic          push_fast_i,
  input  logic [AW-1:0] push_pc_i,
  input  logic [CW-1:0] wreg_i,
  input  logic [CW-1:0] status_i,
  input  logic [CW-1:0] bsr_i,
  input  logic          ret_i,
  input  logic          drop_i,
  input  logic          tos_we_i,
  input  logic [1:0]    tos_sel_i,
  input  logic [7:0]    tos_wdata_i,
  input  logic          flag_clr_i,
  input  logic          err_rst_en_i,
  output logic [AW-1:0] tos_o,
  output logic [PW-1:0] sp_o,
  output logic          full_o,
  output logic          unf_o,
  output logic          rst_req_o,
  output logic [CW-1:0] shd_wreg_o,
  output logic [CW-1:0] shd_status_o,
  output logic [CW-1:0] shd_bsr_o
);
  localparam logic [PW-1:0] TOP = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] sp;
  logic          full_q, unf_q, req_q;
  logic [CW-1:0] sw_q, ss_q, sb_q;

  logic at_top, empty, pop, ovf_ev, unf_ev, patch;
  logic [PW-1:0] wr_idx;

  assign at_top = (sp == TOP);
  assign empty  = (sp == '0);
  assign pop    = !push_i && (ret_i || drop_i);
  assign ovf_ev = push_i && (sp >= TOP - 1'b1);
  assign unf_ev = pop && empty;
  assign patch  = !push_i && !ret_i && !drop_i && tos_we_i && !empty;
  assign wr_idx = at_top ? sp - 1'b1 : sp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp     <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
      sw_q   <= '0;
      ss_q   <= '0;
      sb_q   <= '0;
    end else if (dev_rst_i) begin
      sp    <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= err_rst_en_i && (ovf_ev || unf_ev);
      full_q <= (full_q && !flag_clr_i) || ovf_ev;
      unf_q  <= (unf_q && !flag_clr_i) || unf_ev;
      if (push_i) begin
        if (!at_top) sp <= sp + 1'b1;
        if (push_fast_i) begin
          sw_q <= wreg_i;
          ss_q <= status_i;
          sb_q <= bsr_i;
        end
      end else if (pop && !empty) begin
        sp <= sp - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni && !dev_rst_i) begin
      if (push_i) begin
        mem[wr_idx] <= push_pc_i;
      end else if (patch) begin
        case (tos_sel_i)
          2'd0: mem[sp - 1'b1][7:0]    <= tos_wdata_i;
          2'd1: mem[sp - 1'b1][15:8]   <= tos_wdata_i;
          2'd2: mem[sp - 1'b1][AW-1:16] <= tos_wdata_i[AW-17:0];
          default: ;
        endcase
      end
    end
  end

  assign tos_o        = empty ? '0 : mem[sp - 1'b1];
  assign sp_o         = sp;
  assign full_o       = full_q;
  assign unf_o        = unf_q;
  assign rst_req_o    = req_q;
  assign shd_wreg_o   = sw_q;
  assign shd_status_o = ss_q;
  assign shd_bsr_o    = sb_q;
endmodule

// File: rtl/retstack_chk.sv
`timescale 1ns/1ps
module retstack_chk #(
  parameter int DEPTH = 31,
  parameter int PW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dev_rst_i,
  input logic          push_i,
  input logic          ret_i,
  input logic          drop_i,
  input logic          flag_clr_i,
  input logic [PW-1:0] sp_o,
  input logic          full_o,
  input logic          unf_o,
  input logic          rst_req_o
);
  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !dev_rst_i && sp_o < PW'(DEPTH)) |=> (sp_o == $past(sp_o) + 1'b1));
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !dev_rst_i && sp_o == PW'(DEPTH)) |=> (sp_o == PW'(DEPTH) && full_o));
  // R3
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && (ret_i || drop_i) && !dev_rst_i && sp_o != '0) |=> (sp_o == $past(sp_o) - 1'b1));
  // R5
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && (ret_i || drop_i) && !dev_rst_i && sp_o == '0) |=> (unf_o && sp_o == '0));
  // R6
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !flag_clr_i) |=> full_o);
  // R6
  unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !flag_clr_i) |=> unf_o);
  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

bind retstack retstack_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dev_rst_i(dev_rst_i), .push_i(push_i),
  .ret_i(ret_i), .drop_i(drop_i), .flag_clr_i(flag_clr_i), .sp_o(sp_o),
  .full_o(full_o), .unf_o(unf_o), .rst_req_o(rst_req_o)
);

// File: tb/sim_retstack.sv
`timescale 1ns/1ps
module sim_retstack;
  logic clk = 1'b0, rst_ni = 1'b0, dev_rst = 1'b0;
  logic push = 0, pfast = 0, ret = 0, drop = 0, twe = 0, fclr = 0, ren = 0;
  logic [20:0] pc = '0;
  logic [7:0]  wr = '0, st = '0, bs = '0, tdat = '0;
  logic [1:0]  tsel = '0;
  logic [20:0] tos;
  logic [4:0]  sp;
  logic full, unf, rreq;
  logic [7:0] shw, shs, shb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  retstack u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_i(dev_rst), .push_i(push), .push_fast_i(pfast),
    .push_pc_i(pc), .wreg_i(wr), .status_i(st), .bsr_i(bs), .ret_i(ret), .drop_i(drop),
    .tos_we_i(twe), .tos_sel_i(tsel), .tos_wdata_i(tdat), .flag_clr_i(fclr),
    .err_rst_en_i(ren), .tos_o(tos), .sp_o(sp), .full_o(full), .unf_o(unf),
    .rst_req_o(rreq), .shd_wreg_o(shw), .shd_status_o(shs), .shd_bsr_o(shb)
  );

  // op 0 push, 1 return, 2 drop | value | expected return address | sp | tos
  localparam logic [69:0] VEC [8] = '{
    {2'd0, 21'h12345, 21'h0,     5'd1, 21'h12345},
    {2'd0, 21'h1ABCD, 21'h0,     5'd2, 21'h1ABCD},
    {2'd0, 21'h00777, 21'h0,     5'd3, 21'h00777},
    {2'd2, 21'h0,     21'h0,     5'd2, 21'h1ABCD},
    {2'd1, 21'h0,     21'h1ABCD, 5'd1, 21'h12345},
    {2'd0, 21'h0FFFF, 21'h0,     5'd2, 21'h0FFFF},
    {2'd1, 21'h0,     21'h0FFFF, 5'd1, 21'h12345},
    {2'd1, 21'h0,     21'h12345, 5'd0, 21'h0}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic idle_all();
    push = 0; pfast = 0; ret = 0; drop = 0; twe = 0; fclr = 0; dev_rst = 0;
  endtask

  task automatic do_push(input logic [20:0] v, input logic f);
    @(negedge clk); push = 1; pc = v; pfast = f;
    @(negedge clk); idle_all();
  endtask
  task automatic do_ret();
    @(negedge clk); ret = 1; @(negedge clk); idle_all();
  endtask
  task automatic do_drop();
    @(negedge clk); drop = 1; @(negedge clk); idle_all();
  endtask
  task automatic do_tosw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); twe = 1; tsel = s; tdat = d; @(negedge clk); idle_all();
  endtask
  task automatic do_clr();
    @(negedge clk); fclr = 1; @(negedge clk); idle_all();
  endtask
  task automatic do_devrst();
    @(negedge clk); dev_rst = 1; @(negedge clk); idle_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp, 0); chk("R1 tos", tos, 0); chk("R1 full", full, 0);
    chk("R1 unf", unf, 0); chk("R1 rreq", rreq, 0); chk("R1 shadow", {shw, shs, shb}, 0);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) begin
      logic [69:0] e;
      e = VEC[i];
      case (e[69:68])
        2'd0: do_push(e[67:47], 1'b0);
        2'd1: begin chk("R3 return address", tos, e[46:26]); do_ret(); end
        default: do_drop();
      endcase
      chk("R2/R3 sp", sp, e[25:21]);
      chk("R2/R3 tos", tos, e[20:0]);
    end

    // R5 R7 underflow with reset request
    ren = 1;
    chk("R5 empty return address", tos, 0);
    do_ret();
    chk("R5 unf", unf, 1); chk("R5 sp", sp, 0); chk("R7 req", rreq, 1);
    @(negedge clk);
    chk("R7 one cycle", rreq, 0);
    do_devrst();
    chk("R6 unf kept over device reset", unf, 1); chk("R6 sp", sp, 0);
    do_clr();
    chk("R6 clear unf", unf, 0);
    ren = 0;
    do_drop();
    chk("R5 drop unf", unf, 1); chk("R7 disabled", rreq, 0);
    do_clr();

    // R4 overflow
    for (int k = 1; k <= 30; k++) do_push(21'h100 + 21'(k), 1'b0);
    chk("R4 sp30", sp, 30); chk("R4 not full", full, 0);
    do_push(21'h1F001, 1'b0);
    chk("R4 sp31", sp, 31); chk("R4 full", full, 1); chk("R4 tos", tos, 21'h1F001);
    do_push(21'h1F002, 1'b0);
    chk("R4 sp held", sp, 31); chk("R4 overwrite", tos, 21'h1F002);
    do_drop();
    chk("R4 below", tos, 21'h11E); chk("R6 full sticky", full, 1);
    do_devrst();
    chk("R6 full kept", full, 1); chk("R6 sp cleared", sp, 0);
    do_clr();
    chk("R6 clear full", full, 0);

    // R8 byte lane writes
    do_push(21'h0, 1'b0);
    do_tosw(2'd0, 8'hAA);
    do_tosw(2'd1, 8'hBB);
    do_tosw(2'd2, 8'hFF);
    chk("R8 lanes", tos, 21'h1FBBAA);
    do_tosw(2'd2, 8'hE3);
    chk("R8 upper 5 bits", tos, 21'h03BBAA);
    do_tosw(2'd3, 8'h55);
    chk("R8 code 3 ignored", tos, 21'h03BBAA);
    // R10 push wins over a concurrent top write
    @(negedge clk); push = 1; pc = 21'h00042; twe = 1; tsel = 2'd0; tdat = 8'h99;
    @(negedge clk); idle_all();
    chk("R10 push priority", tos, 21'h00042);
    do_drop();
    chk("R10 lower untouched", tos, 21'h03BBAA);
    do_drop();
    do_tosw(2'd0, 8'h55);
    chk("R8 level0 ignored", tos, 0);
    do_push(21'h2, 1'b0);
    chk("R8 no stray write", tos, 21'h2);

    // R9 shadow
    wr = 8'h11; st = 8'h22; bs = 8'h33;
    do_push(21'h3, 1'b1);
    chk("R9 save", {shw, shs, shb}, 24'h112233);
    wr = 8'h44; st = 8'h55; bs = 8'h66;
    do_push(21'h4, 1'b0);
    chk("R9 plain push keeps", {shw, shs, shb}, 24'h112233);

    // R1 power-on reset clears flags
    do_ret(); do_ret(); do_ret(); do_ret();
    chk("R5 set before reset", unf, 1);
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1; @(negedge clk);
    chk("R1 unf after reset", unf, 0); chk("R1 sp after reset", sp, 0);
    finish_run();
  end
endmodule